// File: doc/BRIEF.md
# Programmable Interval Timer with Register Slave

The block is a periodic interval timer that sits behind a small register slave bus with strobe, cycle, write-enable and acknowledge signals. Software writes a modulo value and a control word. Once enabled, a 16-bit counter advances on prescaled clock ticks. When the counter reaches the modulo value it reloads to 1, emits a one-clock rollover pulse and sets a sticky flag. The flag can drive an interrupt line and is cleared by writing a one to it.

Several timers can advance in lockstep. One timer runs as master and exports its prescaled tick on `sync_out`. The others are switched to slave mode and advance only on clocks where their `sync_in` is high. A parameter selects a 16-bit data bus, or an 8-bit bus on which each register is split into a low byte and a high byte. A second parameter selects whether the acknowledge is registered or given in the same cycle.

Top module: `interval_timer`

## Requirements
- R1: After reset, a 16-bit bus reads 0x4000 at address 0 (control), 0x0000 at address 1 (modulo) and 0x0001 at address 2 (counter).
- R2: The writable control fields are enable (bit 0), interrupt enable (bit 1), prescale select (bits 11:8) and slave mode (bit 15). Bit 14 always reads 1, and bit 2 reads the flag. Writing 0xFFFE reads back as 0xCF02.
- R3: The modulo register holds any 16-bit value written to it. Writes to the counter address are ignored, and the counter keeps reading its current value.
- R4: With prescale select p and modulo m (nonzero), a tick occurs every 2^p enabled clocks. The counter runs 1..m and reloads to 1. `roll_pulse` is high for one clock, m*2^p clocks after the enabling write takes effect, and then every m*2^p clocks.
- R5: A modulo of 0 gives a period of 65536 ticks.
- R6: While enable is 0, the counter holds 1 and the prescaler is cleared.
- R7: The flag (control bit 2) sets on each rollover and stays set. A control write with bit 2 = 1 clears it, and a write with bit 2 = 0 leaves it. If a rollover falls in the same cycle as a clearing write, the flag stays set. A write never sets the flag.
- R8: `irq` is high exactly when the flag and the interrupt enable are both 1.
- R9: In master mode, `sync_out` pulses once per prescaled tick. In slave mode, `sync_out` stays low and the counter advances once for each clock in which `sync_in` is high.
- R10: With the default setting, `bus_ack` rises one clock after strobe and cycle are asserted and lasts one clock. A write takes effect in the acknowledge cycle. With the single-cycle parameter set, `bus_ack` follows strobe and cycle in the same cycle.
- R11: With the 8-bit bus, addresses 0/1 are the control low/high bytes, 2/3 are the modulo low/high bytes and 4/5 are the counter low/high bytes. The control high byte resets to 0x40, and writing 0xFF to it reads back 0xCF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid while acknowledged |
| bus_we | input | 1 | Write enable |
| bus_stb | input | 1 | Strobe |
| bus_cyc | input | 1 | Bus cycle active |
| bus_ack | output | 1 | Acknowledge |
| sync_in | input | 1 | Step input used in slave mode |
| sync_out | output | 1 | Prescaled tick exported in master mode |
| roll_pulse | output | 1 | One-clock pulse after each rollover |
| irq | output | 1 | Interrupt request |

## Verification
A rollover and a software write that clears the flag can land on the same clock edge, and the flag must then remain set. The bench provokes this with modulo 1 and prescale 0, so a rollover occurs on every tick. It then issues a clearing control write and checks that `irq` and the flag bit read back still high. A second clear, made while no rollover is due, confirms that the same write does clear the flag when there is no collision.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the interval timer: register width, prescale
// selector width and the decoded control word.
package tmr_pkg;
    localparam int REG_W  = 16;   // register and counter width
    localparam int PS_W   = 4;    // prescale selector width
    localparam int FLAG_B = 2;    // control bit that reads/clears the flag

    typedef struct packed {
        logic            slave;   // advance on sync_in instead of own tick
        logic [PS_W-1:0] ps;      // prescale select, divide by 2**ps
        logic            ien;     // interrupt enable
        logic            en;      // counting enable
    } tmr_ctrl_t;
endpackage

// File: rtl/tmr_prescaler.sv
`timescale 1ns/1ps
// Clock prescaler: while run is high, produces a one-clock tick every
// 2**ps clocks. Assumes ps is stable while running; cleared while idle.
// HAS_PRESCALE = 0 removes the divider and ticks on every running clock.
module tmr_prescaler
    import tmr_pkg::*;
#(
    parameter bit HAS_PRESCALE = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic [PS_W-1:0] ps,
    output logic            tick
);
    localparam int DIV_W = (1 << PS_W) - 1;

    generate
        if (HAS_PRESCALE) begin : g_div
            logic [DIV_W-1:0] div_q;
            logic [DIV_W-1:0] mask;

            // Low ps bits all ones marks the last clock of a period.
            always_comb mask = ~({DIV_W{1'b1}} << ps);
            assign tick = run && ((div_q & mask) == mask);

            // Free-running divider, cleared whenever counting stops.
            always_ff @(posedge clk) begin
                if (!rst_n || !run) div_q <= '0;
                else                div_q <= div_q + 1'b1;
            end
        end else begin : g_nodiv
            logic unused_ps;
            assign unused_ps = ^ps;
            assign tick = run;
        end
    endgenerate
endmodule

// File: rtl/tmr_counter.sv
`timescale 1ns/1ps
// Modulo counter: counts 1..modulo on each step and reloads to 1.
// A modulo of 0 passes through 0xFFFF and 0 (read as 65536) before
// reloading. Held at 1 while run is low.
module tmr_counter
    import tmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             step,
    input  logic [REG_W-1:0] modulo,
    output logic [REG_W-1:0] count,
    output logic             roll_now,
    output logic             roll_q
);
    // Rollover happens on this clock's edge.
    assign roll_now = run && step && (count == modulo);

    // Counter register and registered rollover pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count  <= REG_W'(1);
            roll_q <= 1'b0;
        end else begin
            roll_q <= roll_now;
            if (!run)          count <= REG_W'(1);
            else if (roll_now) count <= REG_W'(1);
            else if (step)     count <= count + 1'b1;
        end
    end

    // R4: a rollover pulse always coincides with the reloaded counter
    p_reload_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
        roll_q |-> (count == REG_W'(1)));

    // R6: an idle counter is parked at 1 on the next clock
    p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (count == REG_W'(1)));
endmodule

// File: rtl/tmr_regs.sv
`timescale 1ns/1ps
// Register slave: decodes control, modulo and counter for a 16-bit
// word bus or an 8-bit byte-split bus (DATA_W must be 8 or 16).
// Holds the control fields, modulo and the sticky rollover flag.
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter bit SINGLE_CYC = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              we,
    input  logic              stb,
    input  logic              cyc,
    output logic [DATA_W-1:0] rdata,
    output logic              ack,
    input  logic [REG_W-1:0]  count,
    input  logic              roll_now,
    output tmr_ctrl_t         ctrl,
    output logic [REG_W-1:0]  modulo,
    output logic              flag
);
    logic             acc, wr;
    logic [1:0]       sel;     // 0 control, 1 modulo, 2 counter, 3 none
    logic [1:0]       be;      // byte lanes written
    logic [REG_W-1:0] w16, rd16;

    assign acc = stb && cyc;
    assign wr  = ack && we;

    generate
        if (DATA_W == 8) begin : g_byte
            // Byte bus: addr[2:1] picks the register, addr[0] the byte.
            always_comb begin
                sel = addr[2:1];
                be  = addr[0] ? 2'b10 : 2'b01;
                w16 = {wdata, wdata};
            end
            assign rdata = addr[0] ? rd16[15:8] : rd16[7:0];
        end else begin : g_word
            // Word bus: one register per address, 3 and above unmapped.
            always_comb begin
                sel = (addr > 3'd2) ? 2'd3 : addr[1:0];
                be  = 2'b11;
                w16 = wdata;
            end
            assign rdata = rd16;
        end

        if (SINGLE_CYC) begin : g_ack_comb
            assign ack = acc;
        end else begin : g_ack_reg
            logic ack_q;
            // One-clock acknowledge, one cycle after the request.
            always_ff @(posedge clk) begin
                if (!rst_n) ack_q <= 1'b0;
                else        ack_q <= acc && !ack_q;
            end
            assign ack = ack_q;

            // R10: acknowledge lasts a single clock
            p_ack_one_clk_r10: assert property (@(posedge clk) disable iff (!rst_n)
                ack |=> !ack);
            // R10: acknowledge only follows a request
            p_ack_after_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(ack) |-> $past(acc));
        end
    endgenerate

    // Read mux over the 16-bit register images.
    always_comb begin
        case (sel)
            2'd0:    rd16 = {ctrl.slave, 1'b1, 2'b00, ctrl.ps, 5'b0,
                             flag, ctrl.ien, ctrl.en};
            2'd1:    rd16 = modulo;
            2'd2:    rd16 = count;
            default: rd16 = '0;
        endcase
    end

    // Control and modulo writes, per byte lane.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl   <= '0;
            modulo <= '0;
        end else if (wr) begin
            if (sel == 2'd0 && be[0]) begin
                ctrl.en  <= w16[0];
                ctrl.ien <= w16[1];
            end
            if (sel == 2'd0 && be[1]) begin
                ctrl.ps    <= w16[11:8];
                ctrl.slave <= w16[15];
            end
            if (sel == 2'd1 && be[0]) modulo[7:0]  <= w16[7:0];
            if (sel == 2'd1 && be[1]) modulo[15:8] <= w16[15:8];
        end
    end

    // Sticky flag: rollover sets it and wins over a clearing write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag <= 1'b0;
        else if (roll_now)
            flag <= 1'b1;
        else if (wr && sel == 2'd0 && be[0] && w16[FLAG_B])
            flag <= 1'b0;
    end

    // R7: the flag rises only from a rollover, never from a write
    p_flag_from_roll_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(roll_now));
endmodule

// File: rtl/interval_timer.sv
`timescale 1ns/1ps
// Programmable interval timer top: register slave, prescaler and modulo
// counter. In master mode the counter steps on the prescaler tick, which
// is also exported on sync_out. In slave mode it steps on sync_in.
module interval_timer
    import tmr_pkg::*;
#(
    parameter int DATA_W       = 16,
    parameter bit SINGLE_CYC   = 1'b0,
    parameter bit HAS_PRESCALE = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_we,
    input  logic              bus_stb,
    input  logic              bus_cyc,
    output logic              bus_ack,
    input  logic              sync_in,
    output logic              sync_out,
    output logic              roll_pulse,
    output logic              irq
);
    tmr_ctrl_t        ctrl;
    logic [REG_W-1:0] modulo, count;
    logic             flag, tick, step, roll_now;

    tmr_regs #(.DATA_W(DATA_W), .SINGLE_CYC(SINGLE_CYC)) regs_i (
        .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wdata(bus_wdata),
        .we(bus_we), .stb(bus_stb), .cyc(bus_cyc), .rdata(bus_rdata),
        .ack(bus_ack), .count(count), .roll_now(roll_now), .ctrl(ctrl),
        .modulo(modulo), .flag(flag)
    );

    tmr_prescaler #(.HAS_PRESCALE(HAS_PRESCALE)) pre_i (
        .clk(clk), .rst_n(rst_n), .run(ctrl.en && !ctrl.slave),
        .ps(ctrl.ps), .tick(tick)
    );

    // Step source: own tick as master, external pulse as slave.
    assign step     = ctrl.slave ? sync_in : tick;
    assign sync_out = tick;
    assign irq      = flag && ctrl.ien;

    tmr_counter cnt_i (
        .clk(clk), .rst_n(rst_n), .run(ctrl.en), .step(step),
        .modulo(modulo), .count(count), .roll_now(roll_now),
        .roll_q(roll_pulse)
    );

    // R9: an enabled slave without a sync pulse holds its count
    p_slave_waits_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.en && ctrl.slave && !sync_in) |=> $stable(count));

    // R9: an exported tick never appears in slave mode
    p_slave_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl.slave |-> !sync_out);
endmodule

// File: tb/interval_timer_tb_top.sv
`timescale 1ns/1ps
module interval_timer_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;   // 50 MHz

    // 16-bit, registered-acknowledge instance
    logic [2:0]  addr = '0;
    logic [15:0] wdata = '0, rdata;
    logic we = 0, stb = 0, cyc = 0, ack, sync_in = 0, sync_out, roll, irq;

    interval_timer dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wdata(wdata),
        .bus_rdata(rdata), .bus_we(we), .bus_stb(stb), .bus_cyc(cyc),
        .bus_ack(ack), .sync_in(sync_in), .sync_out(sync_out),
        .roll_pulse(roll), .irq(irq)
    );

    // 8-bit, single-cycle-acknowledge instance
    logic [2:0] b8_addr = '0;
    logic [7:0] b8_wdata = '0, b8_rdata;
    logic b8_we = 0, b8_stb = 0, b8_cyc = 0, b8_ack, b8_sync_out, b8_roll, b8_irq;

    interval_timer #(.DATA_W(8), .SINGLE_CYC(1'b1)) dut8_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(b8_addr), .bus_wdata(b8_wdata),
        .bus_rdata(b8_rdata), .bus_we(b8_we), .bus_stb(b8_stb), .bus_cyc(b8_cyc),
        .bus_ack(b8_ack), .sync_in(1'b0), .sync_out(b8_sync_out),
        .roll_pulse(b8_roll), .irq(b8_irq)
    );

    int n_chk = 0, n_fail = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // 16-bit access: ack one clock later, write lands on the ack edge.
    // Returns on the negedge right after the committing edge.
    task automatic bus16(input logic w, input logic [2:0] a, input logic [15:0] d,
                         output logic [15:0] r);
        @(negedge clk);
        stb = 1; cyc = 1; we = w; addr = a; wdata = d;
        #1 chk("R10 no same-cycle ack", 32'(ack), 32'd0);
        @(negedge clk);
        chk("R10 ack after one clock", 32'(ack), 32'd1);
        r = rdata;
        @(negedge clk);
        stb = 0; cyc = 0; we = 0;
    endtask

    // 8-bit access with same-cycle acknowledge.
    task automatic bus8(input logic w, input logic [2:0] a, input logic [7:0] d,
                        output logic [7:0] r);
        @(negedge clk);
        b8_stb = 1; b8_cyc = 1; b8_we = w; b8_addr = a; b8_wdata = d;
        #1 chk("R10 single-cycle ack", 32'(b8_ack), 32'd1);
        r = b8_rdata;
        @(negedge clk);
        b8_stb = 0; b8_cyc = 0; b8_we = 0;
    endtask

    // Counts negedges until the rollover pulse is seen (or lim).
    task automatic wait_roll(input int lim, output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!roll && n < lim);
    endtask

    // Stimulus table: {prescale, modulo, expected clocks per period} (R4)
    localparam logic [51:0] VEC [6] = '{
        {4'd0, 16'd4, 32'd4},
        {4'd2, 16'd4, 32'd16},
        {4'd1, 16'd5, 32'd10},
        {4'd3, 16'd1, 32'd8},
        {4'd0, 16'd1, 32'd1},
        {4'd4, 16'd3, 32'd48}
    };

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        logic [15:0] r;
        logic [7:0]  r8;
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values
        bus16(0, 3'd0, 16'h0, r); chk("R1 control reset", 32'(r), 32'h4000);
        bus16(0, 3'd1, 16'h0, r); chk("R1 modulo reset", 32'(r), 32'h0000);
        bus16(0, 3'd2, 16'h0, r); chk("R1 counter reset", 32'(r), 32'h0001);

        // R2 control write mask
        bus16(1, 3'd0, 16'hFFFE, r);
        bus16(0, 3'd0, 16'h0, r); chk("R2 control mask", 32'(r), 32'hCF02);
        bus16(1, 3'd0, 16'h0000, r);
        bus16(0, 3'd0, 16'h0, r); chk("R2 bit14 constant", 32'(r), 32'h4000);

        // R3 modulo read/write, counter not writable
        bus16(1, 3'd1, 16'h5555, r);
        bus16(0, 3'd1, 16'h0, r); chk("R3 modulo 5555", 32'(r), 32'h5555);
        bus16(1, 3'd1, 16'hAAAA, r);
        bus16(0, 3'd1, 16'h0, r); chk("R3 modulo AAAA", 32'(r), 32'hAAAA);
        bus16(1, 3'd2, 16'hFFFE, r);
        bus16(0, 3'd2, 16'h0, r); chk("R3 counter write ignored", 32'(r), 32'h0001);

        // R4 table walk: first latency and period, then R6 idle state
        for (int i = 0; i < 6; i++) begin
            logic [3:0]  ps;
            logic [15:0] md;
            logic [31:0] ex;
            {ps, md, ex} = VEC[i];
            bus16(1, 3'd1, md, r);
            bus16(1, 3'd0, {4'b0, ps, 8'h03}, r);
            wait_roll(200, n); chk("R4 first rollover latency", 32'(n), ex);
            wait_roll(200, n); chk("R4 rollover period", 32'(n), ex);
            chk("R8 irq with flag and ien", 32'(irq), 32'd1);
            bus16(1, 3'd0, 16'h0000, r);
            bus16(1, 3'd0, 16'h0004, r);
            chk("R7 flag cleared", 32'(irq), 32'd0);
            bus16(0, 3'd2, 16'h0, r); chk("R6 idle counter is 1", 32'(r), 32'h0001);
        end

        // R9 master tick export: ps=2 gives 5 ticks in 20 clocks
        bus16(1, 3'd0, 16'h0201, r);
        n = 0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (sync_out) n++;
        end
        chk("R9 sync_out pulse count", 32'(n), 32'd5);
        bus16(1, 3'd0, 16'h0000, r);

        // R9 slave mode: steps only on sync_in, modulo 3
        bus16(1, 3'd1, 16'd3, r);
        bus16(1, 3'd0, 16'h8001, r);
        for (int k = 0; k < 3; k++) begin
            sync_in = 1'b1;
            @(negedge clk);
            sync_in = 1'b0;
            chk("R9 slave rolls on third sync", 32'(roll), (k == 2) ? 32'd1 : 32'd0);
            n = 0;
            for (int j = 0; j < 3; j++) begin
                @(negedge clk);
                if (roll || sync_out) n++;
            end
            chk("R9 slave quiet without sync", 32'(n), 32'd0);
        end
        bus16(1, 3'd0, 16'h0000, r);
        bus16(1, 3'd0, 16'h0004, r);

        // R7/R8 flag behaviour, modulo 200
        bus16(1, 3'd1, 16'd200, r);
        bus16(1, 3'd0, 16'h0003, r);
        wait_roll(300, n);
        @(negedge clk);
        chk("R8 irq after rollover", 32'(irq), 32'd1);
        bus16(0, 3'd0, 16'h0, r); chk("R7 flag reads set", 32'(r), 32'h4007);
        bus16(1, 3'd0, 16'h0003, r);
        chk("R7 write of 0 keeps flag", 32'(irq), 32'd1);
        bus16(1, 3'd0, 16'h0007, r);
        chk("R7 write of 1 clears flag", 32'(irq), 32'd0);
        bus16(1, 3'd0, 16'h0001, r);
        wait_roll(300, n);
        @(negedge clk);
        chk("R8 irq masked without ien", 32'(irq), 32'd0);
        bus16(0, 3'd0, 16'h0, r); chk("R8 flag set while masked", 32'(r), 32'h4005);

        // R7 collision: rollover on every tick, clearing write loses
        bus16(1, 3'd0, 16'h0000, r);
        bus16(1, 3'd1, 16'd1, r);
        bus16(1, 3'd0, 16'h0003, r);
        bus16(1, 3'd0, 16'h0007, r);
        chk("R7 set wins over clear", 32'(irq), 32'd1);
        bus16(0, 3'd0, 16'h0, r); chk("R7 flag after collision", 32'(r), 32'h4007);
        bus16(1, 3'd0, 16'h0000, r);
        bus16(1, 3'd0, 16'h0004, r);

        // R5 modulo 0 behaves as 65536
        bus16(1, 3'd1, 16'd0, r);
        bus16(1, 3'd0, 16'h0001, r);
        wait_roll(70000, n); chk("R5 modulo zero period", 32'(n), 32'd65536);
        bus16(1, 3'd0, 16'h0004, r);

        // R11 byte-split map on the 8-bit instance
        bus8(0, 3'd0, 8'h0, r8); chk("R11 ctrl low reset", 32'(r8), 32'h00);
        bus8(0, 3'd1, 8'h0, r8); chk("R11 ctrl high reset", 32'(r8), 32'h40);
        bus8(0, 3'd4, 8'h0, r8); chk("R11 count low reset", 32'(r8), 32'h01);
        bus8(0, 3'd5, 8'h0, r8); chk("R11 count high reset", 32'(r8), 32'h00);
        bus8(1, 3'd1, 8'hFF, r8);
        bus8(0, 3'd1, 8'h0, r8); chk("R11 ctrl high mask", 32'(r8), 32'hCF);
        bus8(0, 3'd0, 8'h0, r8); chk("R11 ctrl low untouched", 32'(r8), 32'h00);
        bus8(1, 3'd0, 8'hFE, r8);
        bus8(0, 3'd0, 8'h0, r8); chk("R11 ctrl low mask", 32'(r8), 32'h02);
        bus8(1, 3'd3, 8'h99, r8);
        bus8(0, 3'd3, 8'h0, r8); chk("R11 modulo high byte", 32'(r8), 32'h99);
        bus8(0, 3'd2, 8'h0, r8); chk("R11 modulo low untouched", 32'(r8), 32'h00);
        bus8(1, 3'd4, 8'hAA, r8);
        bus8(0, 3'd4, 8'h0, r8); chk("R11 count byte not writable", 32'(r8), 32'h01);
        bus8(1, 3'd3, 8'h00, r8);
        bus8(1, 3'd2, 8'h02, r8);
        bus8(1, 3'd1, 8'h00, r8);
        bus8(1, 3'd0, 8'h01, r8);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!b8_roll && n < 50);
        chk("R11 byte-bus rollover latency", 32'(n), 32'd2);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule